// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one 10-bit successive-approximation conversion at a time for an analog front end that lives outside it. It divides the I/O clock by 1, 2, 4 or 8 into a one-cycle reference tick. Each conversion then runs through three phases. First comes a sample-and-hold window of 2 or 4 reference periods. Next come ten bit decisions, one per reference period, taken from a single comparator input. Last comes a two-period transfer phase, which opens with a one-cycle buffer write strobe and an interrupt request.

The enable flag is held inside the block and is written by software through a write strobe. In one-time mode, hardware clears the flag when the transfer finishes. In continuous mode, a new sampling window follows the transfer directly, and this repeats until software clears the flag. If the flag is cleared while sampling or bit decisions are in progress, the conversion is abandoned at the next reference tick and is never transferred.

Top module: `adc_sar_seq`

## Requirements
- R1: The reference tick has a period of 2^div_sel_i I/O clocks (div_sel_i 0,1,2,3 gives 1,2,4,8).
- R2: sh_o stays high for exactly S reference periods per conversion, where S is 2 when smp_sel_i=0 and 4 when smp_sel_i=1.
- R3: In continuous mode, consecutive wr_o pulses are (12+S) x 2^div_sel_i I/O clocks apart (112 for divide-by-8 with S=2).
- R4: Bits are resolved MSB first. The first trial code after sampling is 10'h200. At each tick a bit is kept when cmp_i=1 (input ≥ DAC) and cleared otherwise, so the result is the largest code not above the input.
- R5: After en_o becomes 1 from idle, sh_o rises within 1 to 2^div_sel_i I/O clocks.
- R6: wr_o and irq_o are high together for exactly one I/O clock per finished conversion, and result_o holds the new value in that same cycle.
- R7: In one-time mode (cont_i=0), en_o reads 0 after the transfer, and no further sampling starts.
- R8: In continuous mode (cont_i=1), sampling restarts right after each transfer while en_o stays 1.
- R9: Clearing the flag during sampling or bit decisions returns the block to idle with dac_code_o=0, and produces no wr_o or irq_o for that conversion.
- R10: After reset, en_o, sh_o, wr_o, irq_o, dac_code_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_we_i | input | 1 | Software write strobe for the enable flag |
| en_wdata_i | input | 1 | Value written to the enable flag |
| div_sel_i | input | 2 | Reference divide select (1,2,4,8) |
| smp_sel_i | input | 1 | Sampling length select: 0 = 2 periods, 1 = 4 periods |
| cont_i | input | 1 | 1 = continuous mode, 0 = one-time mode |
| cmp_i | input | 1 | Comparator decision: 1 when input ≥ DAC code |
| en_o | output | 1 | Current enable flag |
| dac_code_o | output | 10 | Trial code for the DAC (0 outside bit phase) |
| sh_o | output | 1 | Sample-and-hold control |
| wr_o | output | 1 | Data-buffer write strobe |
| irq_o | output | 1 | Interrupt request pulse |
| result_o | output | 10 | Last transferred conversion result |

## Verification
The bench models the comparator from an ideal input level. Conversions are run at the rail codes 0 and 1023, at the midpoint 512, and at the alternating patterns 341 and 682. A mistake in bit order or in the keep/clear decision corrupts these patterns in different bit positions. Each pattern is paired with a different divide and sampling setting, so that the sampling-window length, the start latency and the spacing of continuous strobes separate the four divide ratios and the two sampling lengths. Aborts are issued in the middle of the bit phase, in both one-time and continuous mode, to show that a half-resolved code never reaches the buffer.

// File: rtl/adc_sar_pkg.sv
package adc_sar_pkg;
  localparam int RES_W     = 10;
  localparam int SEL_W     = 2;
  localparam int SMP_SHORT = 2;
  localparam int SMP_LONG  = 4;
  localparam int XFER_CLKS = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_BITS, ST_XFER} seq_state_e;

  // I/O clocks per reference period
  function automatic int unsigned ref_ratio(input logic [SEL_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  // reference periods spent in sample-and-hold
  function automatic int unsigned smp_periods(input logic sel);
    return sel ? SMP_LONG : SMP_SHORT;
  endfunction

  // I/O clocks for one whole conversion
  function automatic int unsigned conv_io_clocks(input logic [SEL_W-1:0] dsel, input logic ssel);
    return (RES_W + XFER_CLKS + smp_periods(ssel)) * ref_ratio(dsel);
  endfunction
endpackage

// File: rtl/adc_refclk_div.sv
module adc_refclk_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt_q;

  assign ratio  = (CNT_W+1)'(1) << div_sel_i;
  assign lim    = CNT_W'(ratio - (CNT_W+1)'(1));
  assign tick_o = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R1: ticks never fall in adjacent cycles unless dividing by one
  a_r1_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_sel_i != '0) |=> (!tick_o || div_sel_i == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_sar_pkg::*;
#(
  parameter int RES_BITS = RES_W,
  parameter int SMP_S    = SMP_SHORT,
  parameter int SMP_L    = SMP_LONG,
  parameter int XFER_N   = XFER_CLKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic smp_sel_i,
  input  logic cont_i,
  output logic sh_o,
  output logic bits_o,
  output logic idle_o,
  output logic load_o,
  output logic step_o,
  output logic xfer_o,
  output logic oneshot_done_o
);
  localparam int CNT_W = $clog2(RES_BITS + SMP_L + 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] pcnt_q;
  logic [CNT_W-1:0] smp_last;
  logic             bits_last, xfer_last, xfer_q;

  assign smp_last  = smp_sel_i ? CNT_W'(SMP_L - 1) : CNT_W'(SMP_S - 1);
  assign bits_last = (pcnt_q == CNT_W'(RES_BITS - 1));
  assign xfer_last = (pcnt_q == CNT_W'(XFER_N - 1));

  assign sh_o           = (state_q == ST_SAMPLE);
  assign bits_o         = (state_q == ST_BITS);
  assign idle_o         = (state_q == ST_IDLE);
  assign load_o         = tick_i && en_i && sh_o && (pcnt_q == smp_last);
  assign step_o         = tick_i && en_i && bits_o;
  assign oneshot_done_o = tick_i && (state_q == ST_XFER) && xfer_last && !cont_i;
  assign xfer_o         = xfer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pcnt_q  <= '0;
      xfer_q  <= 1'b0;
    end else begin
      xfer_q <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (en_i) begin
            state_q <= ST_SAMPLE;
            pcnt_q  <= '0;
          end
          ST_SAMPLE: begin
            if (!en_i) state_q <= ST_IDLE;
            else if (pcnt_q == smp_last) begin
              state_q <= ST_BITS;
              pcnt_q  <= '0;
            end else pcnt_q <= pcnt_q + 1'b1;
          end
          ST_BITS: begin
            if (!en_i) state_q <= ST_IDLE;
            else if (bits_last) begin
              state_q <= ST_XFER;
              pcnt_q  <= '0;
              xfer_q  <= 1'b1;
            end else pcnt_q <= pcnt_q + 1'b1;
          end
          ST_XFER: begin
            if (xfer_last) begin
              state_q <= (en_i && cont_i) ? ST_SAMPLE : ST_IDLE;
              pcnt_q  <= '0;
            end else pcnt_q <= pcnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: a cleared flag at a tick outside the transfer leaves the sequencer idle
  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !en_i && state_q != ST_XFER) |=> idle_o);
  // R6: the transfer strobe lasts one I/O clock
  a_r6_xfer_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o);
  // R2: the sampling window is entered only from idle or a finished transfer
  a_r2_sample_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh_o) |-> $past(tick_i));
endmodule

// File: rtl/adc_sar_reg.sv
module adc_sar_reg #(
  parameter int RES_BITS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] code_o,
  output logic [RES_BITS-1:0] result_o
);
  localparam int IDX_W = $clog2(RES_BITS);

  logic [RES_BITS-1:0] code_q, code_nxt, res_q;
  logic [IDX_W-1:0]    idx_q;

  always_comb begin
    code_nxt = code_q;
    if (!cmp_i) code_nxt[idx_q] = 1'b0;
    if (idx_q != '0) code_nxt[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      idx_q  <= '0;
      res_q  <= '0;
    end else if (load_i) begin
      code_q <= {1'b1, {(RES_BITS-1){1'b0}}};
      idx_q  <= IDX_W'(RES_BITS - 1);
    end else if (step_i) begin
      code_q <= code_nxt;
      if (idx_q == '0) res_q <= code_nxt;
      else             idx_q <= idx_q - 1'b1;
    end
  end

  assign code_o   = code_q;
  assign result_o = res_q;

  // R4: bits below the current trial bit are still zero
  a_r4_low_bits_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> ((code_q & ((RES_BITS'(1) << idx_q) - 1'b1)) == '0));
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_sar_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             en_wdata_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             smp_sel_i,
  input  logic             cont_i,
  input  logic             cmp_i,
  output logic             en_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             sh_o,
  output logic             wr_o,
  output logic             irq_o,
  output logic [RES_W-1:0] result_o
);
  localparam int WAIT_W = (1 << SEL_W) + 2;

  logic en_q, ref_tick, bits_active, seq_idle, load, step, xfer, oneshot_done;
  logic [RES_W-1:0] sar_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           en_q <= 1'b0;
    else if (en_we_i)      en_q <= en_wdata_i;
    else if (oneshot_done) en_q <= 1'b0;
  end

  adc_refclk_div #(.SEL_W(SEL_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_sel_i(div_sel_i), .tick_o(ref_tick));

  adc_seq_ctrl #(.RES_BITS(RES_W), .SMP_S(SMP_SHORT), .SMP_L(SMP_LONG), .XFER_N(XFER_CLKS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(ref_tick), .en_i(en_q),
    .smp_sel_i(smp_sel_i), .cont_i(cont_i), .sh_o(sh_o), .bits_o(bits_active),
    .idle_o(seq_idle), .load_o(load), .step_o(step), .xfer_o(xfer),
    .oneshot_done_o(oneshot_done));

  adc_sar_reg #(.RES_BITS(RES_W)) u_sar (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .step_i(step),
    .cmp_i(cmp_i), .code_o(sar_code), .result_o(result_o));

  assign en_o       = en_q;
  assign dac_code_o = bits_active ? sar_code : '0;
  assign wr_o       = xfer;
  assign irq_o      = xfer;

  // start latency watch for the assertion below
  logic [WAIT_W-1:0] idle_wait_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idle_wait_q <= '0;
    else if (en_q && seq_idle)  idle_wait_q <= idle_wait_q + 1'b1;
    else                        idle_wait_q <= '0;
  end

  // R4: the bit phase opens with the MSB as the trial bit
  a_r4_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bits_active) |-> (dac_code_o == {1'b1, {(RES_W-1){1'b0}}}));
  // R5: idle with the flag set lasts at most one reference period
  a_r5_start_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(idle_wait_q) <= ref_ratio(div_sel_i));
  // R9: a transfer only follows an enabled bit phase
  a_r9_wr_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(en_q));
  // R10 / R2: no trial code while sampling
  a_r2_sh_no_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_o |-> (dac_code_o == '0));
endmodule

// File: tb/adc_sar_seq_tb.sv
`timescale 1ns/1ps
module adc_sar_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_we = 1'b0, en_wdata = 1'b0, smp_sel = 1'b0, cont = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [9:0] vin = 10'd0;
  logic cmp, en_o, sh, wr, irq;
  logic [9:0] dac, result;

  always #2.5 clk = ~clk;
  assign cmp = (vin >= dac);

  adc_sar_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_we_i(en_we), .en_wdata_i(en_wdata),
    .div_sel_i(div_sel), .smp_sel_i(smp_sel), .cont_i(cont), .cmp_i(cmp),
    .en_o(en_o), .dac_code_o(dac), .sh_o(sh), .wr_o(wr), .irq_o(irq),
    .result_o(result));

  int checks = 0, fails = 0;
  int cyc = 0, wr_count = 0, sh_rises = 0, sh_len = 0;
  logic [9:0] exp_q[$];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ratio(input logic [1:0] s); return 1 << s; endfunction
  function automatic int smp(input logic s); return s ? 4 : 2; endfunction

  // monitor / scoreboard
  logic sh_prev = 1'b0, wr_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (wr) begin
        wr_count++;
        chk(irq == 1'b1, "R6 irq with wr", irq, 1);
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected wr", wr, 0);
        else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk(result == e, "R4 result", result, e);
        end
      end else chk(irq == 1'b0, "R6 irq without wr", irq, 0);
      if (wr && wr_prev) chk(1'b0, "R6 wr width", 2, 1);
      if (sh && !sh_prev) begin sh_rises++; sh_len = 0; end
      if (sh) sh_len++;
      if (!sh && sh_prev && dac != 10'd0) begin
        chk(dac == 10'h200, "R4 first trial", dac, 10'h200);
        chk(sh_len == smp(smp_sel) * ratio(div_sel), "R2/R1 sample length",
            sh_len, smp(smp_sel) * ratio(div_sel));
      end
      sh_prev = sh;
      wr_prev = wr;
    end
  end

  task automatic write_en(input logic v);
    @(negedge clk); en_we = 1'b1; en_wdata = v;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic wait_wr(output int at_cyc);
    int n0;
    n0 = wr_count;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (wr_count != n0) break;
    end
    chk(wr_count != n0, "R6 wr seen", wr_count - n0, 1);
    at_cyc = cyc;
  endtask

  task automatic start_and_latency();
    int lat;
    write_en(1'b1);
    lat = 0;
    while (!sh && lat < 64) begin @(negedge clk); lat++; end
    chk(lat >= 1 && lat <= ratio(div_sel), "R5 start latency", lat, ratio(div_sel));
  endtask

  task automatic one_shot(input logic [1:0] d, input logic s, input logic [9:0] v);
    int t, n0, r0;
    @(negedge clk); div_sel = d; smp_sel = s; cont = 1'b0; vin = v;
    exp_q.push_back(v);
    start_and_latency();
    wait_wr(t);
    repeat (3 * ratio(d)) @(negedge clk);
    chk(en_o == 1'b0, "R7 flag cleared", en_o, 0);
    n0 = wr_count; r0 = sh_rises;
    repeat (2 * (12 + smp(s)) * ratio(d)) @(negedge clk);
    chk(wr_count == n0 && sh_rises == r0, "R7 no restart", sh_rises - r0, 0);
  endtask

  task automatic cont_run(input logic [1:0] d, input logic s, input logic [9:0] v);
    int t1, t2, t3, n0;
    @(negedge clk); div_sel = d; smp_sel = s; cont = 1'b1; vin = v;
    repeat (3) exp_q.push_back(v);
    start_and_latency();
    wait_wr(t1);
    wait_wr(t2);
    chk(t2 - t1 == (12 + smp(s)) * ratio(d), "R3 spacing", t2 - t1, (12 + smp(s)) * ratio(d));
    wait_wr(t3);
    chk(t3 - t2 == (12 + smp(s)) * ratio(d), "R8 back-to-back", t3 - t2, (12 + smp(s)) * ratio(d));
    chk(en_o == 1'b1, "R8 flag held", en_o, 1);
    // land the clear in the bit phase of the fourth conversion
    repeat ((2 + smp(s) + 3) * ratio(d) - 1) @(negedge clk);
    chk(dac != 10'd0, "R9 in bit phase", dac, 1);
    n0 = wr_count;
    write_en(1'b0);
    repeat (20 * ratio(d)) @(negedge clk);
    chk(wr_count == n0, "R9 no wr after abort", wr_count - n0, 0);
    chk(!sh && dac == 10'd0, "R9 idle after abort", dac, 0);
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
  endtask

  task automatic one_shot_abort(input logic [1:0] d, input logic s);
    int n0;
    @(negedge clk); div_sel = d; smp_sel = s; cont = 1'b0; vin = 10'd777;
    start_and_latency();
    repeat ((smp(s) + 4) * ratio(d)) @(negedge clk);
    n0 = wr_count;
    write_en(1'b0);
    repeat (20 * ratio(d)) @(negedge clk);
    chk(wr_count == n0, "R9 one-time abort no wr", wr_count - n0, 0);
    chk(dac == 10'd0 && !sh, "R9 one-time abort idle", dac, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(en_o == 0, "R10 en", en_o, 0);
    chk(sh == 0, "R10 sh", sh, 0);
    chk(wr == 0 && irq == 0, "R10 wr/irq", wr, 0);
    chk(dac == 0, "R10 dac", dac, 0);
    chk(result == 0, "R10 result", result, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    one_shot(2'd0, 1'b0, 10'd0);
    one_shot(2'd1, 1'b1, 10'd1023);
    one_shot(2'd3, 1'b0, 10'd341);
    one_shot(2'd2, 1'b1, 10'd682);
    one_shot(2'd0, 1'b1, 10'd512);
    cont_run(2'd3, 1'b0, 10'd600);
    cont_run(2'd1, 1'b1, 10'd5);
    one_shot_abort(2'd2, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule